// File: doc/BRIEF.md
# Oversampled Serial Receive Engine

This block turns an asynchronous serial line into received characters. A programmable pre-divider makes a tick at sixteen times the bit rate. On each high-to-low edge of the line the receiver restarts its sixteen-phase counter, so every frame is timed afresh. Each bit is then sampled at its centre. The data width, the parity mode and the number of configured stop bits come from static configuration inputs. These must not change while a frame is in flight.

Each character is reported in a single cycle, together with its parity and framing status. The engine also watches for a line held low for a whole frame. It flags the start of such a break and, later, the moment the line rises again. When the surrounding logic signals that received characters are still waiting to be read, the engine raises a one-cycle timeout event once three frame times pass with no new start bit.

Top module: `serial_rx_engine`

## Requirements
- R1: The oversample tick fires once every `div_val`+1 clock cycles, so one bit lasts 16×(`div_val`+1) cycles. `div_val` spans 0 to 4095.
- R2: The line passes through a two-flop synchroniser. A high-to-low edge starts a frame and restarts the phase counter. If the line reads high at the start bit's centre (the 8th tick), the pulse is dropped as a glitch and no character is produced.
- R3: Data bits arrive least significant bit first. With `wide`=1 there are 8 of them. With `wide`=0 there are 7, and `rx_data[7]` is 0.
- R4: With `par_en`=1, one parity bit follows the data. The expected value is the XOR of the data bits when `par_odd`=0, and its inverse when `par_odd`=1. `rx_perr` is 1 when the received bit differs from it.
- R5: With `par_en`=0, no parity bit is taken and `rx_perr` is always 0.
- R6: Exactly one stop bit is sampled, whatever `stop2` says. A 0 there sets `rx_ferr`. A frame may follow straight after a single stop bit even when `stop2`=1.
- R7: `rx_valid` is a one-cycle pulse. It is raised at the stop-bit centre and carries `rx_data`, `rx_perr` and `rx_ferr` in the same cycle.
- R8: If a frame has all data bits 0, a parity bit of 0 (when parity is enabled) and a 0 stop bit, `brk_begin` pulses together with that frame's `rx_valid`. A framing error on non-zero data gives no `brk_begin`.
- R9: After `brk_begin`, no character is produced while the line stays low. A one-cycle `brk_end` pulse follows once the synchronised line is high, and reception resumes normally after that.
- R10: While `pending`=1 and the receiver sits idle, `idle_evt` pulses once after 3×16×L ticks, where L = 1 + data bits + parity bit + stop bits (2 when `stop2`=1). A new frame or `pending`=0 restarts the count.
- R11: While reset is active and right after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | 12 | Pre-divider setting; tick period is div_val+1 cycles |
| wide | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | Two stop bits configured (affects timeout length only) |
| rxd | input | 1 | Asynchronous serial line, idle high |
| pending | input | 1 | Received characters are still unread |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity mismatch for this character |
| rx_ferr | output | 1 | Stop bit read as 0 for this character |
| brk_begin | output | 1 | One-cycle pulse: break detected |
| brk_end | output | 1 | One-cycle pulse: line returned high after break |
| idle_evt | output | 1 | One-cycle pulse: idle timeout with unread data |

## Verification
Some properties are checked on every cycle: the tick spacing against the divider setting, the single-cycle width of the character and idle strobes, and the zero top bit in narrow mode. They also cover the absence of parity errors with parity off and the null-frame-plus-framing-error shape of every break start. Finally, no character may appear between a break start and its end. What only the bench scenarios can show is that bits are assembled in the right order and checked against the right parity sense. The same holds for glitch rejection, frames following a single stop bit, and the exact length of the idle timeout for each frame shape.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_BRK
   } rx_state_e;

   typedef struct packed {
      logic wide;
      logic par_en;
      logic par_odd;
      logic stop2;
   } rx_cfg_t;

   // number of bit periods in one frame for a given configuration
   function automatic int frame_len(input rx_cfg_t cfg, input int data_w);
      int n;
      n = 1 + (cfg.wide ? data_w : data_w - 1);
      n = n + (cfg.par_en ? 1 : 0);
      n = n + (cfg.stop2 ? 2 : 1);
      return n;
   endfunction

endpackage

// File: rtl/serial_rx_div.sv
module serial_rx_div #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= div_val) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic line,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serial_rx_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= rx_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign line = chain[STAGES-1];
   assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              fall,
   input  rx_cfg_t           cfg,
   output logic              quiet,
   output logic              char_vld,
   output logic [DATA_W-1:0] char_data,
   output logic              char_perr,
   output logic              char_ferr,
   output logic              brk_begin,
   output logic              brk_end
);
   localparam int PH_W  = $clog2(OSR);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [PH_W-1:0]  MID_PH    = PH_W'(OSR / 2 - 1);
   localparam logic [IDX_W-1:0] LAST_WIDE = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] LAST_NARR = IDX_W'(DATA_W - 2);

   rx_state_e         state;
   logic [PH_W-1:0]   ph;
   logic [IDX_W-1:0]  bidx;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              pend;

   logic              par_exp;
   logic              null_frame;
   logic [IDX_W-1:0]  last_idx;

   always_comb begin
      par_exp    = cfg.par_odd ? ~(^shreg) : ^shreg;
      null_frame = (shreg == '0) && (!cfg.par_en || !par_bit);
      last_idx   = cfg.wide ? LAST_WIDE : LAST_NARR;
   end

   assign quiet = (state == RX_IDLE) && !pend && !fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         ph        <= '0;
         bidx      <= '0;
         shreg     <= '0;
         par_bit   <= 1'b0;
         pend      <= 1'b0;
         char_vld  <= 1'b0;
         char_data <= '0;
         char_perr <= 1'b0;
         char_ferr <= 1'b0;
         brk_begin <= 1'b0;
         brk_end   <= 1'b0;
      end else begin
         char_vld  <= 1'b0;
         brk_begin <= 1'b0;
         brk_end   <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (tick && (pend || fall)) begin
                  state <= RX_START;
                  ph    <= '0;
                  pend  <= 1'b0;
               end else if (fall) begin
                  pend <= 1'b1;
               end
            end
            RX_BRK: begin
               if (line) begin
                  brk_end <= 1'b1;
                  state   <= RX_IDLE;
               end
            end
            default: begin
               if (tick) begin
                  ph <= ph + 1'b1;
                  if (ph == MID_PH) begin
                     case (state)
                        RX_START: begin
                           if (line) begin
                              state <= RX_IDLE;
                           end else begin
                              state <= RX_DATA;
                              bidx  <= '0;
                              shreg <= '0;
                           end
                        end
                        RX_DATA: begin
                           shreg[bidx] <= line;
                           if (bidx == last_idx) begin
                              state <= cfg.par_en ? RX_PAR : RX_STOP;
                           end else begin
                              bidx <= bidx + 1'b1;
                           end
                        end
                        RX_PAR: begin
                           par_bit <= line;
                           state   <= RX_STOP;
                        end
                        default: begin
                           char_vld  <= 1'b1;
                           char_data <= shreg;
                           char_perr <= cfg.par_en && (par_bit != par_exp);
                           char_ferr <= ~line;
                           if (!line && null_frame) begin
                              brk_begin <= 1'b1;
                              state     <= RX_BRK;
                           end else begin
                              state <= RX_IDLE;
                           end
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/serial_rx_idle.sv
module serial_rx_idle
   import serial_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DATA_W      = 8,
   parameter int IDLE_FRAMES = 3
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    armed,
   input  rx_cfg_t cfg,
   output logic    idle_evt
);
   localparam int MAX_LEN = DATA_W + 4;
   localparam int CNT_W   = $clog2(IDLE_FRAMES * OSR * MAX_LEN + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             fired;

   always_comb begin
      limit = CNT_W'(IDLE_FRAMES * OSR * frame_len(cfg, DATA_W) - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         fired    <= 1'b0;
         idle_evt <= 1'b0;
      end else begin
         idle_evt <= 1'b0;
         if (!armed) begin
            cnt   <= '0;
            fired <= 1'b0;
         end else if (tick && !fired) begin
            if (cnt == limit) begin
               idle_evt <= 1'b1;
               fired    <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
   import serial_rx_pkg::*;
#(
   parameter int DIV_W       = 12,
   parameter int OSR         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_FRAMES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              wide,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop2,
   input  logic              rxd,
   input  logic              pending,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_perr,
   output logic              rx_ferr,
   output logic              brk_begin,
   output logic              brk_end,
   output logic              idle_evt
);
   generate
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("serial_rx_engine: OSR must be a power of two, at least 4");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_rx_engine: DATA_W must be at least 2");
      end
      if (IDLE_FRAMES < 1) begin : g_bad_idle
         $error("serial_rx_engine: IDLE_FRAMES must be at least 1");
      end
   endgenerate

   rx_cfg_t cfg;
   logic    bit_tick;
   logic    line_s;
   logic    line_fall;
   logic    rx_quiet;

   assign cfg = '{wide: wide, par_en: par_en, par_odd: par_odd, stop2: stop2};

   serial_rx_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_val (div_val),
      .tick    (bit_tick)
   );

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .rx_in (rxd),
      .line  (line_s),
      .fall  (line_fall)
   );

   serial_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (bit_tick),
      .line      (line_s),
      .fall      (line_fall),
      .cfg       (cfg),
      .quiet     (rx_quiet),
      .char_vld  (rx_valid),
      .char_data (rx_data),
      .char_perr (rx_perr),
      .char_ferr (rx_ferr),
      .brk_begin (brk_begin),
      .brk_end   (brk_end)
   );

   serial_rx_idle #(.OSR(OSR), .DATA_W(DATA_W), .IDLE_FRAMES(IDLE_FRAMES)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (bit_tick),
      .armed    (pending && rx_quiet),
      .cfg      (cfg),
      .idle_evt (idle_evt)
   );
endmodule

// File: rtl/serial_rx_engine_chk.sv
module serial_rx_engine_chk #(
   parameter int DIV_W  = 12,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DIV_W-1:0]  div_val,
   input logic              tick,
   input logic              wide,
   input logic              par_en,
   input logic              pending,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_perr,
   input logic              rx_ferr,
   input logic              brk_begin,
   input logic              brk_end,
   input logic              idle_evt
);
   logic [DIV_W-1:0] gap;
   logic [DIV_W-1:0] div_q;
   logic             gap_ok;
   logic             brk_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap     <= '0;
         div_q   <= '0;
         gap_ok  <= 1'b0;
         brk_act <= 1'b0;
      end else begin
         div_q <= div_val;
         gap   <= tick ? '0 : gap + 1'b1;
         if (div_val != div_q) gap_ok <= 1'b0;
         else if (tick)        gap_ok <= 1'b1;
         if (brk_begin)    brk_act <= 1'b1;
         else if (brk_end) brk_act <= 1'b0;
      end
   end

   AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && gap_ok && div_val == div_q) |-> (gap == div_val)); // R1
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R7
   AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !wide) |-> !rx_data[DATA_W-1]); // R3
   AST_NO_PERR_WO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !par_en) |-> !rx_perr); // R5
   AST_BREAK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      brk_begin |-> (rx_valid && rx_ferr && rx_data == '0)); // R8
   AST_BREAK_END_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      brk_end |-> brk_act); // R9
   AST_NO_CHAR_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !brk_act); // R9
   AST_IDLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt |=> !idle_evt); // R10
   AST_IDLE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt |-> $past(pending)); // R10
endmodule

bind serial_rx_engine serial_rx_engine_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .div_val   (div_val),
   .tick      (bit_tick),
   .wide      (wide),
   .par_en    (par_en),
   .pending   (pending),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .rx_perr   (rx_perr),
   .rx_ferr   (rx_ferr),
   .brk_begin (brk_begin),
   .brk_end   (brk_end),
   .idle_evt  (idle_evt)
);

// File: tb/serial_rx_engine_bench.sv
module serial_rx_engine_bench;

   typedef struct packed {
      logic [7:0] d;
      logic       w;
      logic       pe;
      logic       po;
      logic       badpar;
      logic       stopv;
      logic       xperr;
      logic       xferr;
   } vec_t;

   // data, wide, parity on, odd, corrupt parity, stop value, exp perr, exp ferr
   localparam int NVEC = 9;
   localparam vec_t VEC [NVEC] = '{
      '{8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8'h3D, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8'hD3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      '{8'h2A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] div_val = '0;
   logic        wide = 1'b1;
   logic        par_en = 1'b0;
   logic        par_odd = 1'b0;
   logic        stop2 = 1'b0;
   logic        rxd = 1'b1;
   logic        pending = 1'b0;
   logic        rx_valid;
   logic [7:0]  rx_data;
   logic        rx_perr;
   logic        rx_ferr;
   logic        brk_begin;
   logic        brk_end;
   logic        idle_evt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int         n_char = 0;
   int         n_bb = 0;
   int         n_be = 0;
   int         n_id = 0;
   logic [7:0] first_d = '0;
   logic [7:0] got_d = '0;
   logic       got_p = 1'b0;
   logic       got_f = 1'b0;

   always #5 clk = ~clk;

   serial_rx_engine u_serial_rx_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_val   (div_val),
      .wide      (wide),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .stop2     (stop2),
      .rxd       (rxd),
      .pending   (pending),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_perr   (rx_perr),
      .rx_ferr   (rx_ferr),
      .brk_begin (brk_begin),
      .brk_end   (brk_end),
      .idle_evt  (idle_evt)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         if (n_char == 0) first_d = rx_data;
         n_char = n_char + 1;
         got_d  = rx_data;
         got_p  = rx_perr;
         got_f  = rx_ferr;
      end
      if (brk_begin) n_bb = n_bb + 1;
      if (brk_end)   n_be = n_be + 1;
      if (idle_evt)  n_id = n_id + 1;
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_counts();
      n_char = 0;
      n_bb   = 0;
      n_be   = 0;
      n_id   = 0;
   endtask

   task automatic send(input logic [7:0] d, input logic badpar, input logic stopv,
                       input int gap_bits);
      int         bp;
      logic [7:0] m;
      logic       p;
      bp = 16 * (int'(div_val) + 1);
      m  = wide ? d : {1'b0, d[6:0]};
      p  = par_odd ? ~(^m) : ^m;
      if (badpar) p = ~p;
      rxd = 1'b0;
      repeat (bp) @(negedge clk);
      for (int i = 0; i < (wide ? 8 : 7); i++) begin
         rxd = m[i];
         repeat (bp) @(negedge clk);
      end
      if (par_en) begin
         rxd = p;
         repeat (bp) @(negedge clk);
      end
      rxd = stopv;
      repeat (bp) @(negedge clk);
      rxd = 1'b1;
      repeat (gap_bits * bp) @(negedge clk);
   endtask

   task automatic measure_idle(input string tag, input int expect_cycles);
      int n;
      pending = 1'b0;
      repeat (5) @(negedge clk);
      clear_counts();
      pending = 1'b1;
      n = 0;
      while (!idle_evt && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check_eq({tag, " timeout within 2 cycles of expected"},
               (n >= expect_cycles - 2 && n <= expect_cycles + 2) ? 1 : 0, 1);
      repeat (700) @(negedge clk);
      check_eq({tag, " single idle pulse"}, n_id, 1);
      pending = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs quiet in reset
      check_eq("R11 outputs in reset",
               int'({rx_valid, rx_perr, rx_ferr, brk_begin, brk_end, idle_evt, |rx_data}), 0);
      rst_n = 1'b1;
      repeat (60) @(negedge clk);
      check_eq("R11 outputs after reset",
               int'({rx_valid, rx_perr, rx_ferr, brk_begin, brk_end, idle_evt, |rx_data}), 0);
      check_eq("R11 no events after reset", n_char + n_bb + n_be + n_id, 0);

      // vector table: R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         wide    = VEC[v].w;
         par_en  = VEC[v].pe;
         par_odd = VEC[v].po;
         stop2   = 1'b0;
         repeat (4) @(negedge clk);
         clear_counts();
         send(VEC[v].d, VEC[v].badpar, VEC[v].stopv, 2);
         check_eq("R7 one character per frame", n_char, 1);
         check_eq("R3 data bits", int'(got_d),
                  int'(VEC[v].w ? VEC[v].d : {1'b0, VEC[v].d[6:0]}));
         if (VEC[v].pe) check_eq("R4 parity flag", int'(got_p), int'(VEC[v].xperr));
         else           check_eq("R5 parity flag off", int'(got_p), 0);
         check_eq("R6 stop flag", int'(got_f), int'(VEC[v].xferr));
         check_eq("R8 no break on this frame", n_bb, 0);
      end

      // R2: short low glitch gives no character, next frame still received
      wide = 1'b1; par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0;
      clear_counts();
      rxd = 1'b0;
      repeat (3) @(negedge clk);
      rxd = 1'b1;
      repeat (80) @(negedge clk);
      check_eq("R2 glitch rejected", n_char, 0);
      send(8'h6E, 1'b0, 1'b1, 2);
      check_eq("R2 frame after glitch count", n_char, 1);
      check_eq("R2 frame after glitch data", int'(got_d), 32'h6E);

      // R6: two stop bits configured, frames sent back to back with one stop bit
      stop2 = 1'b1;
      clear_counts();
      send(8'h12, 1'b0, 1'b1, 0);
      send(8'h34, 1'b0, 1'b1, 2);
      check_eq("R6 back-to-back count", n_char, 2);
      check_eq("R6 back-to-back first", int'(first_d), 32'h12);
      check_eq("R6 back-to-back second", int'(got_d), 32'h34);
      check_eq("R6 single stop checked", int'(got_f), 0);
      stop2 = 1'b0;

      // R1: slower bit rate through the pre-divider
      div_val = 12'd2;
      repeat (20) @(negedge clk);
      clear_counts();
      send(8'h96, 1'b0, 1'b1, 2);
      check_eq("R1 divided rate count", n_char, 1);
      check_eq("R1 divided rate data", int'(got_d), 32'h96);
      div_val = 12'd0;
      repeat (20) @(negedge clk);

      // R8 R9: break, held low, then released
      clear_counts();
      send(8'h00, 1'b0, 1'b0, 0);
      rxd = 1'b0;
      repeat (30 * 16) @(negedge clk);
      check_eq("R8 break begin", n_bb, 1);
      check_eq("R8 break character flagged", int'(got_f), 1);
      check_eq("R9 no character during break", n_char, 1);
      check_eq("R9 no end while low", n_be, 0);
      rxd = 1'b1;
      repeat (40) @(negedge clk);
      check_eq("R9 break end", n_be, 1);
      clear_counts();
      send(8'hC7, 1'b0, 1'b1, 2);
      check_eq("R9 reception after break", int'(got_d), 32'hC7);
      check_eq("R9 count after break", n_char, 1);

      // R10: idle timeout lengths for two frame shapes
      wide = 1'b1; par_en = 1'b0; stop2 = 1'b0;
      measure_idle("R10 8N1", 3 * 16 * 10);
      wide = 1'b0; par_en = 1'b1; stop2 = 1'b1;
      measure_idle("R10 7P2", 3 * 16 * 11);
      // R10: no timeout without pending
      clear_counts();
      repeat (700) @(negedge clk);
      check_eq("R10 no timeout when nothing pending", n_id, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule